// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator with Level Re-check

The block gathers eleven synchronous interrupt lines into one processor notification. A notification is a single bus write request. It carries an address and a data word, and both are taken from one programmed target word. The block latches a line into its pending store only when the line rises while it is enabled. A line that is already high when software enables it raises nothing. A notification goes out when the pending store passes from empty to non-empty. Edges that arrive while the store is still non-empty only add bits to it.

Software learns which lines fired by reading the request register, and that read also empties the store. A second register empties the store without reporting anything. Because the block reacts to edges and not to levels, a third register shows the live, registered level of every line. After it has served the pending lines, software can use this register to find sources that are still asserted and emulate level-triggered sharing.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending store, the enable mask and the target word are zero, and neither `note_valid` nor `reg_rvalid` is asserted.
- R2: A rising edge on line i while mask bit i is set latches pending bit i. Line bit order: PCI INTA..INTF on bits 0..5, the external bus interrupt on bit 6, the serial port on bit 10.
- R3: An edge on a line whose mask bit is clear latches nothing. A line that is already high when its mask bit is set latches nothing.
- R4: The mask register (byte offset 0x08) keeps only the implemented bits 0x5FF. Bit 9 always reads 0, and line 9 never latches.
- R5: A read of the request register (offset 0x04) returns the pending bits in `reg_rdata` with `reg_rvalid` one cycle after the request, and it empties the store.
- R6: A read of the pending-clear register (offset 0x0C) returns 0 and empties the store. It leaves the live-level register unchanged.
- R7: The live-level register (offset 0x10) returns the level of each line as sampled on the previous clock edge.
- R8: When the store passes from empty to non-empty, one notification is raised. `note_addr` is the target word with its low 5 bits cleared, and `note_data` is those 5 bits. Both are held stable with `note_valid` until `note_ready`.
- R9: Further edges while the store is non-empty only add bits, and they raise no second notification.
- R10: A rising edge in the same cycle as a request-register read stays pending and raises a new notification. The read itself returns only the bits pending before that edge.
- R11: The target register (offset 0x00) is written and read back as a full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 11 | Synchronous interrupt lines |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| note_valid | output | 1 | Notification write request |
| note_ready | input | 1 | Notification write accepted |
| note_addr | output | 32 | Notification write address |
| note_data | output | 32 | Notification write data |

## Verification
The bench goes after a line that is already high when it is unmasked. A design that reacts to level would send a notification there when it should not. It also hits a request read that meets a new edge in the same cycle. A design that lets the clear win would lose that interrupt for good, with no second notification. The unimplemented bit 9 and the pending-clear read are checked against the live-level register, which catches a store that leaks unimplemented bits or a clear that wipes the level view. A stalled `note_ready` shows whether address and data stay put and whether only one write is issued for a burst of edges.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Byte offsets of the register port.
    localparam int unsigned OFF_TARGET = 32'h00;
    localparam int unsigned OFF_REQ    = 32'h04;
    localparam int unsigned OFF_MASK   = 32'h08;
    localparam int unsigned OFF_PCLR   = 32'h0C;
    localparam int unsigned OFF_LIVE   = 32'h10;

    typedef enum logic [2:0] {
        SEL_TARGET,
        SEL_REQ,
        SEL_MASK,
        SEL_PCLR,
        SEL_LIVE,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
    parameter int unsigned N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] level;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = lines_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign rise_o  = lines_i & ~st_q.level;

    // A rise seen now must show up as a high level on the next edge.
    assert_rise_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((level_o & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending #(
    parameter int unsigned N         = 11,
    parameter logic [N-1:0] IMPL_MASK = 11'h5FF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] pend_o,
    output logic         fire_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic     was_empty;

    always_comb begin
        st_d      = st_q;
        was_empty = (st_q.pend == '0) || clr_i;
        if (clr_i) st_d.pend = '0;
        st_d.pend = (st_d.pend | set_i) & IMPL_MASK;
        fire_o    = was_empty && (st_d.pend != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    assert_only_impl_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~IMPL_MASK) == '0);

    assert_read_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (pend_o == '0));

    assert_edge_survives_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i & IMPL_MASK) != '0) |=> (pend_o != '0));

    assert_accumulate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/irqagg_notify.sv
module irqagg_notify #(
    parameter int unsigned AW     = 32,
    parameter int unsigned DATA_W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic [AW-1:0] target_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] data_o
);
    localparam logic [AW-1:0] DATA_FIELD = AW'((64'd1 << DATA_W) - 64'd1);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [AW-1:0] data;
    } note_st_t;

    note_st_t st_d, st_q;
    logic     busy;

    always_comb begin
        st_d = st_q;
        busy = st_q.valid && !ready_i;
        if (st_q.valid && ready_i) st_d.valid = 1'b0;
        // A request that is still waiting already covers a new fire.
        if (fire_i && !busy) begin
            st_d.valid = 1'b1;
            st_d.addr  = target_i & ~DATA_FIELD;
            st_d.data  = target_i & DATA_FIELD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign addr_o  = st_q.addr;
    assign data_o  = st_q.data;

    assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));

    assert_fire_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> valid_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int unsigned  N_LINES     = 11,
    parameter logic [10:0]  IMPL_MASK   = 11'h5FF,
    parameter int unsigned  ADDR_W      = 5,
    parameter int unsigned  DW          = 32,
    parameter int unsigned  NOTE_DATA_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               reg_rvalid,
    output logic               note_valid,
    input  logic               note_ready,
    output logic [DW-1:0]      note_addr,
    output logic [DW-1:0]      note_data
);
    localparam logic [N_LINES-1:0] IMPL = N_LINES'(IMPL_MASK);

    typedef struct packed {
        logic [DW-1:0]      target;
        logic [N_LINES-1:0] mask;
        logic [DW-1:0]      rdata;
        logic               rvalid;
    } top_st_t;

    top_st_t            st_d, st_q;
    reg_sel_e           sel;
    logic [N_LINES-1:0] level, rise, set_bits, pend;
    logic               clr, fire;

    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFF_TARGET): sel = SEL_TARGET;
            ADDR_W'(OFF_REQ):    sel = SEL_REQ;
            ADDR_W'(OFF_MASK):   sel = SEL_MASK;
            ADDR_W'(OFF_PCLR):   sel = SEL_PCLR;
            ADDR_W'(OFF_LIVE):   sel = SEL_LIVE;
            default:             sel = SEL_NONE;
        endcase
    end

    irqagg_edge #(.N(N_LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines),
        .level_o (level),
        .rise_o  (rise)
    );

    assign set_bits = rise & st_q.mask;
    assign clr      = reg_en && !reg_we && (sel == SEL_REQ || sel == SEL_PCLR);

    irqagg_pending #(.N(N_LINES), .IMPL_MASK(IMPL)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_bits),
        .clr_i  (clr),
        .pend_o (pend),
        .fire_o (fire)
    );

    irqagg_notify #(.AW(DW), .DATA_W(NOTE_DATA_W)) u_note (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .target_i (st_q.target),
        .ready_i  (note_ready),
        .valid_o  (note_valid),
        .addr_o   (note_addr),
        .data_o   (note_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (reg_en && reg_we) begin
            case (sel)
                SEL_TARGET: st_d.target = reg_wdata;
                SEL_MASK:   st_d.mask   = reg_wdata[N_LINES-1:0] & IMPL;
                default:    ;
            endcase
        end else if (reg_en) begin
            st_d.rvalid = 1'b1;
            case (sel)
                SEL_TARGET: st_d.rdata = st_q.target;
                SEL_REQ:    st_d.rdata = DW'(pend);
                SEL_MASK:   st_d.rdata = DW'(st_q.mask);
                SEL_LIVE:   st_d.rdata = DW'(level);
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata  = st_q.rdata;
    assign reg_rvalid = st_q.rvalid;

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && pend == '0 && (rise & st_q.mask) == '0) |=> (pend == '0));

    assert_rise_notifies_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0 && (rise & st_q.mask) != '0) |=> note_valid);
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [10:0] irq_lines = '0;
    logic        reg_en = 0, reg_we = 0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        note_valid;
    logic        note_ready = 1;
    logic [31:0] note_addr, note_data;

    int checks = 0, fails = 0, notes = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .note_valid(note_valid), .note_ready(note_ready),
        .note_addr(note_addr), .note_data(note_data)
    );

    always @(posedge clk) if (rst_n && note_valid && note_ready) notes <= notes + 1;

    // mask, pulse, expected request bits
    localparam logic [32:0] VEC [6] = '{
        {11'h7FF, 11'h001, 11'h001},
        {11'h03F, 11'h0C0, 11'h000},
        {11'h040, 11'h0C0, 11'h040},
        {11'h400, 11'h401, 11'h400},
        {11'h5FF, 11'h7FF, 11'h5FF},
        {11'h200, 11'h200, 11'h000}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
        @(negedge clk); reg_en = 0; d = reg_rdata;
        if (!reg_rvalid) begin
            checks++; fails++;
            $display("FAIL R5: actual rvalid 0 expected 1");
        end
    endtask

    task automatic pulse(logic [10:0] p);
        @(negedge clk); irq_lines = p;
        @(negedge clk); irq_lines = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 note_valid", {31'b0, note_valid}, 0);
        check("R1 rvalid", {31'b0, reg_rvalid}, 0);
        rst_n = 1;
        rd(5'h04, v); check("R1 pending", v, 0);
        rd(5'h08, v); check("R1 mask", v, 0);
        rd(5'h00, v); check("R1 target", v, 0);

        // R11 target
        wr(5'h00, 32'hA000_0013);
        rd(5'h00, v); check("R11 target readback", v, 32'hA000_0013);

        // Table walk: R2, R3, R4, R5, R8
        foreach (VEC[i]) begin
            wr(5'h08, {21'b0, VEC[i][32:22]});
            rd(5'h0C, v);
            n0 = notes;
            pulse(VEC[i][21:11]);
            rd(5'h04, v);
            check("R2 request bits", v, {21'b0, VEC[i][10:0]});
            check("R8 notification count", notes - n0, (VEC[i][10:0] != 0) ? 1 : 0);
            rd(5'h04, v);
            check("R5 cleared after read", v, 0);
        end

        // R4 mask implemented bits
        wr(5'h08, 32'hFFF);
        rd(5'h08, v); check("R4 mask readback", v, 32'h5FF);

        // R3 already-high line then unmasked
        wr(5'h08, 0);
        @(negedge clk); irq_lines = 11'h004;
        repeat (3) @(negedge clk);
        n0 = notes;
        wr(5'h08, 32'h004);
        repeat (3) @(negedge clk);
        rd(5'h04, v); check("R3 pre-high line", v, 0);
        check("R3 no notification", notes - n0, 0);
        @(negedge clk); irq_lines = 0;

        // R6 and R7
        wr(5'h08, 32'h5FF);
        pulse(11'h001);
        @(negedge clk); irq_lines = 11'h002;
        repeat (2) @(negedge clk);
        rd(5'h10, v); check("R7 live level", v, 32'h002);
        rd(5'h0C, v); check("R6 pclr reads zero", v, 0);
        rd(5'h04, v); check("R6 store emptied", v, 0);
        rd(5'h10, v); check("R6 live unchanged", v, 32'h002);
        @(negedge clk); irq_lines = 0;
        repeat (2) @(negedge clk);
        rd(5'h0C, v);

        // R8 hold under stall, R9 accumulate
        note_ready = 0;
        n0 = notes;
        pulse(11'h010);
        check("R8 valid held", {31'b0, note_valid}, 1);
        check("R8 addr", note_addr, 32'hA000_0000);
        check("R8 data", note_data, 32'h13);
        pulse(11'h020);
        @(negedge clk); note_ready = 1;
        repeat (3) @(negedge clk);
        check("R9 single notification", notes - n0, 1);
        rd(5'h04, v); check("R9 accumulated", v, 32'h030);

        // R10 read meets new edge
        pulse(11'h001);
        n0 = notes;
        @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = 5'h04; irq_lines = 11'h008;
        @(negedge clk); reg_en = 0; v = reg_rdata;
        check("R10 read returns old bits", v, 32'h001);
        irq_lines = 0;
        repeat (3) @(negedge clk);
        check("R10 new notification", notes - n0, 1);
        rd(5'h04, v); check("R10 edge kept", v, 32'h008);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule